// File: doc/BRIEF.md
# SPI Clock-Calendar Register Target

This block is the register side of a serial real-time clock. A host reaches it over a four-wire SPI link that has an active-high chip enable, a clock that idles high, and a data line in each direction. Behind the link is a byte-addressed register file. It holds seven BCD time and date registers, two four-byte alarm sets, a control byte, a status byte, a trickle-charge setting byte and a bank of general-purpose RAM. Time-keeping, alarm comparison, interrupt outputs and charging circuits are outside the block. Only the storage and the way it is reached are modelled here.

Every transaction opens with an address byte. Its most significant bit set asks for a write, and its lower seven bits name the first register. Each data byte that follows goes to, or comes from, the next address in turn, so the whole clock can be set or read in one burst. A write-protect flag in the control byte freezes all other locations. Software clears that flag in a separate control write and then programs the time.

The SPI pins are sampled on the system clock through a synchronizer, so SCK must be several system clocks slower than `clk`.

Top module: `rtcspi_target`

## Requirements
- R1: After reset the control register at 0x0F reads 0x40 (bit 6, write-protect, set). Every other location reads 0x00.
- R2: While control bit 6 is set, a write to any address other than 0x0F leaves that location unchanged.
- R3: While control bit 6 is set, a control write changes only bit 6. While it is clear, a control write stores bits 0, 1, 2 and 6 (mask 0x47), and the other control bits read 0.
- R4: Raising CE opens a transaction. The first byte carries the start address in bits 6:0 and the direction in bit 7 (1 = write, 0 = read). The data bytes that follow go to consecutive addresses, so a burst opened with 0x80 fills 0x00 through 0x06 in order.
- R5: Stored bits are limited per register: 0x00–0x02 keep mask 0x7F, 0x03 keeps 0x07, 0x04 keeps 0x3F, 0x05 keeps 0x1F, and 0x06–0x0E and 0x11 keep all 8 bits. Status at 0x10 always reads 0x00.
- R6: User RAM from 0x20 to 0x20+RAM_BYTES-1 stores all 8 bits. Every other unlisted address reads 0x00 and ignores writes.
- R7: The address pointer advances by one after every data byte and wraps from 0x7F to 0x00.
- R8: A byte left incomplete when CE falls is discarded and writes nothing.
- R9: MISO is released (high impedance) while CE is low.
- R10: The link runs in SPI mode 3, MSB first. The host samples on the rising SCK edge and the target changes MISO after the falling edge. The MSB of the first read byte is valid before the first rising edge that follows the address byte.
- R11: The hours register stores both the 12-hour encoding (bit 6 mode, bit 5 PM) and the 24-hour BCD encoding without alteration, within its 0x7F mask.
- R12: Write-protect is evaluated byte by byte. A burst byte that sets control bit 6 blocks the later bytes of the same burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than SCK |
| rst_n | input | 1 | Synchronous active-low reset |
| ce | input | 1 | Chip enable, active high, frames a transaction |
| sck | input | 1 | Serial clock, idles high |
| mosi | input | 1 | Serial data from host, MSB first |
| miso | output | 1 | Serial data to host, high impedance while CE is low |

## Verification
The bench builds the block with its defaults: two synchronizer stages and 32 bytes of RAM. With these values the 7-bit address space holds implemented registers, holes and the RAM bank. Single-byte write sweeps over all 128 addresses, using two complementary data patterns, followed by full-space burst reads, therefore cover every mask, every hole and the RAM edges. A read that starts at 0x7F checks the pointer wrap. Directed transactions cover the write-protect sequencing, the case where protection is set part-way through a burst, and an aborted byte.

// File: rtl/rtcspi_pkg.sv
// Shared constants for the SPI clock-calendar target.
// Assumes a 7-bit register address space, with bit 7 of the
// address byte used as the direction flag.
package rtcspi_pkg;
    localparam int          REG_AW     = 7;
    localparam int          CORE_REGS  = 18;      // 0x00..0x11
    localparam logic [6:0]  A_HOURS    = 7'h02;
    localparam logic [6:0]  A_CTRL     = 7'h0F;
    localparam logic [6:0]  A_RAM      = 7'h20;
    localparam int          WP_BIT     = 6;
    localparam logic [7:0]  CTRL_INIT  = 8'h40;
    localparam logic [7:0]  WP_MASK    = 8'h40;

    // Bits each core register can hold; status (0x10) holds none.
    function automatic logic [7:0] core_mask(input int idx);
        case (idx)
            0, 1, 2: core_mask = 8'h7F;
            3:       core_mask = 8'h07;
            4:       core_mask = 8'h3F;
            5:       core_mask = 8'h1F;
            15:      core_mask = 8'h47;
            16:      core_mask = 8'h00;
            default: core_mask = 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/rtcspi_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous pins.
// Assumes the bits of the bundle change far apart compared with clk.
module rtcspi_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    // Shift the sampled pins through the register chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
        end else begin
            pipe[0] <= d;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/rtcspi_frame.sv
// Serial framing engine: SPI mode 3, MSB first, byte assembly, the
// address pointer and the read shifter. Assumes synchronized pins.
// Dropping CE clears all framing state, so a partial byte is lost.
module rtcspi_frame
    import rtcspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              sck,
    input  logic              mosi,
    input  logic [7:0]        rd_data,
    output logic [REG_AW-1:0] rd_addr,
    output logic              wr_en,
    output logic [REG_AW-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              miso_bit
);
    logic              sck_d;
    logic [2:0]        bitcnt;
    logic [6:0]        rx_sh;
    logic              first_q;
    logic              write_q;
    logic [REG_AW-1:0] ptr;
    logic [7:0]        tx_sh;
    logic              sck_rise, sck_fall, byte_done;
    logic [7:0]        rx_byte;
    logic              load_tx;

    assign sck_rise  = ce && sck && !sck_d;
    assign sck_fall  = ce && !sck && sck_d;
    assign rx_byte   = {rx_sh, mosi};
    assign byte_done = sck_rise && (bitcnt == 3'd7);
    assign load_tx   = byte_done && (first_q ? !rx_byte[7] : !write_q);

    assign rd_addr  = first_q ? rx_byte[6:0] : ptr;
    assign wr_en    = byte_done && !first_q && write_q;
    assign wr_addr  = ptr;
    assign wr_data  = rx_byte;
    assign miso_bit = tx_sh[7];

    // Remember the previous SCK level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck;
    end

    // Count bits and shift MOSI in on rising SCK edges.
    always_ff @(posedge clk) begin
        if (!rst_n || !ce) begin
            bitcnt <= 3'd0;
            rx_sh  <= 7'd0;
        end else if (sck_rise) begin
            bitcnt <= bitcnt + 3'd1;
            rx_sh  <= rx_byte[6:0];
        end
    end

    // Capture the address byte, then step the pointer per data byte.
    always_ff @(posedge clk) begin
        if (!rst_n || !ce) begin
            first_q <= 1'b1;
            write_q <= 1'b0;
            ptr     <= '0;
        end else if (byte_done) begin
            if (first_q) begin
                first_q <= 1'b0;
                write_q <= rx_byte[7];
                ptr     <= rx_byte[7] ? rx_byte[6:0] : rx_byte[6:0] + 7'd1;
            end else begin
                ptr <= ptr + 7'd1;
            end
        end
    end

    // Load read data at byte boundaries and shift it out on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n || !ce)                 tx_sh <= 8'd0;
        else if (load_tx)                  tx_sh <= rd_data;
        else if (sck_fall && bitcnt != 0)  tx_sh <= {tx_sh[6:0], 1'b0};
    end

    // R7: each completed data byte moves the pointer by exactly one.
    p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && !first_q) |=> (!ce || ptr == $past(ptr) + 7'd1));
endmodule

// File: rtl/rtcspi_regs.sv
// Register storage: time, alarms, control, status, charger setting and
// user RAM, with per-register bit masks and write-protect gating.
// Assumes at most one write strobe per cycle from the framing engine.
module rtcspi_regs
    import rtcspi_pkg::*;
#(
    parameter int RAM_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int RAM_IW = (RAM_BYTES > 1) ? $clog2(RAM_BYTES) : 1;

    logic [CORE_REGS*8-1:0] core_flat;
    logic [7:0]             ram_q [RAM_BYTES];
    logic                   wp;
    logic                   w_ram, r_ram;
    logic [RAM_IW-1:0]      ram_wi, ram_ri;

    assign wp     = core_flat[int'(A_CTRL)*8 + WP_BIT];
    assign w_ram  = int'(wr_addr) >= int'(A_RAM) && int'(wr_addr) < int'(A_RAM) + RAM_BYTES;
    assign r_ram  = int'(rd_addr) >= int'(A_RAM) && int'(rd_addr) < int'(A_RAM) + RAM_BYTES;
    assign ram_wi = RAM_IW'(wr_addr - A_RAM);
    assign ram_ri = RAM_IW'(rd_addr - A_RAM);

    for (genvar i = 0; i < CORE_REGS; i++) begin : g_core
        localparam logic [7:0] MASK = core_mask(i);
        logic [7:0] q;
        logic       hit;
        assign hit = wr_en && (wr_addr == REG_AW'(i));
        assign core_flat[i*8 +: 8] = q;

        if (i == int'(A_CTRL)) begin : g_ctrl
            // Control: only the protect flag moves while protected.
            always_ff @(posedge clk) begin
                if (!rst_n)   q <= CTRL_INIT;
                else if (hit) q <= wp ? ((q & ~WP_MASK) | (wr_data & WP_MASK))
                                      : (wr_data & MASK);
            end
            // R3: a protected control write keeps every bit except bit 6.
            p_ctrl_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (hit && wp) |=> (q[7] == $past(q[7]) && q[5:0] == $past(q[5:0])));
            // R1: reset leaves write-protect set.
            p_reset_wp_r1: assert property (@(posedge clk)
                !rst_n |=> q[WP_BIT]);
        end else begin : g_data
            // Ordinary register: masked store unless protected.
            always_ff @(posedge clk) begin
                if (!rst_n)          q <= 8'h00;
                else if (hit && !wp) q <= wr_data & MASK;
            end
            // R2: protected writes leave the register untouched.
            p_wp_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (hit && wp) |=> $stable(q));
        end
    end

    // User RAM bank: full bytes, gated by write-protect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < RAM_BYTES; j++) ram_q[j] <= 8'h00;
        end else if (wr_en && w_ram && !wp) begin
            ram_q[ram_wi] <= wr_data;
        end
    end

    // Read mux: core registers, RAM, or zero for holes.
    always_comb begin
        rd_data = 8'h00;
        if (int'(rd_addr) < CORE_REGS) rd_data = core_flat[int'(rd_addr)*8 +: 8];
        else if (r_ram)                rd_data = ram_q[ram_ri];
    end
endmodule

// File: rtl/rtcspi_target.sv
// SPI clock-calendar register target (top). Synchronizes the pins,
// frames bytes and drives the register file. Assumes SCK half-periods
// of at least SYNC_STAGES+2 clk cycles.
module rtcspi_target
    import rtcspi_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RAM_BYTES   = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic sck,
    input  logic mosi,
    output logic miso
);
    logic [2:0]        pins_s;
    logic              ce_s, sck_s, mosi_s;
    logic [7:0]        rd_data, wr_data;
    logic [REG_AW-1:0] rd_addr, wr_addr;
    logic              wr_en, miso_bit;

    rtcspi_sync #(.W(3), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .d({ce, sck, mosi}), .q(pins_s)
    );
    assign {ce_s, sck_s, mosi_s} = pins_s;

    rtcspi_frame frame_i (
        .clk(clk), .rst_n(rst_n), .ce(ce_s), .sck(sck_s), .mosi(mosi_s),
        .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .miso_bit(miso_bit)
    );

    rtcspi_regs #(.RAM_BYTES(RAM_BYTES)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Drive MISO only inside a transaction.
    assign miso = ce_s ? miso_bit : 1'bz;

    // R8: register writes happen only while the frame is open.
    p_wr_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ce_s);
endmodule

// File: tb/rtcspi_target_tb_top.sv
module rtcspi_target_tb_top;
    localparam int HALF = 6;
    localparam int RAMB = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce = 1'b0, sck = 1'b1, mosi = 1'b0;
    wire  miso;
    int   checks = 0, fails = 0;
    bit   done = 1'b0;
    logic [7:0] model [128];
    logic [7:0] rbuf  [128];

    always #4 clk = ~clk;   // 125 MHz
    pullup (miso);

    rtcspi_target #(.SYNC_STAGES(2), .RAM_BYTES(RAMB)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce(ce), .sck(sck), .mosi(mosi), .miso(miso)
    );

    function automatic logic [7:0] bmask(input int a);
        if (a <= 2) return 8'h7F;
        if (a == 3) return 8'h07;
        if (a == 4) return 8'h3F;
        if (a == 5) return 8'h1F;
        if (a <= 14) return 8'hFF;
        if (a == 15) return 8'h47;
        if (a == 16) return 8'h00;
        if (a == 17) return 8'hFF;
        if (a >= 32 && a < 32 + RAMB) return 8'hFF;
        return 8'h00;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic ce_on();
        ce = 1'b1; repeat (HALF) @(negedge clk);
    endtask

    task automatic ce_off();
        ce = 1'b0; repeat (HALF) @(negedge clk);
    endtask

    task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = 8'h00;
        for (int b = 7; b > 7 - n; b--) begin
            sck = 1'b0; mosi = tx[b]; repeat (HALF) @(negedge clk);
            rx[b] = miso; sck = 1'b1; repeat (HALF) @(negedge clk);
        end
    endtask

    task automatic wr_burst(input logic [6:0] a, input int n);
        logic [7:0] junk;
        ce_on(); bits({1'b1, a}, 8, junk);
        for (int k = 0; k < n; k++) bits(rbuf[k], 8, junk);
        ce_off();
    endtask

    task automatic wr1(input logic [6:0] a, input logic [7:0] d);
        rbuf[0] = d; wr_burst(a, 1);
    endtask

    task automatic rd_burst(input logic [6:0] a, input int n);
        logic [7:0] v;
        ce_on(); bits({1'b0, a}, 8, v);
        for (int k = 0; k < n; k++) begin bits(8'h00, 8, v); rbuf[k] = v; end
        ce_off();
    endtask

    task automatic rd1(input logic [6:0] a, output logic [7:0] d);
        rd_burst(a, 1); d = rbuf[0];
    endtask

    task automatic chk_released(input string req);
        checks++;
        if (miso !== 1'b1) begin
            fails++;
            $display("FAIL %s: actual %b expected released (pulled 1)", req, miso);
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        logic [7:0] t7 [7];
        repeat (10) @(negedge clk);
        chk_released("R9 during reset");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset contents over the whole space
        rd_burst(7'h00, 128);
        for (int a = 0; a < 128; a++) chk("R1 reset value", rbuf[a], (a == 15) ? 8'h40 : 8'h00);
        chk_released("R9 after read");

        // R2 / R12: protected writes to time and RAM are dropped
        wr1(7'h00, 8'h45); rd1(7'h00, v); chk("R2 protected seconds", v, 8'h00);
        wr1(7'h20, 8'h99); rd1(7'h20, v); chk("R2 protected RAM", v, 8'h00);

        // R3: control sequencing
        wr1(7'h0F, 8'h47); rd1(7'h0F, v); chk("R3 protected ctrl write", v, 8'h40);
        wr1(7'h0F, 8'h00); rd1(7'h0F, v); chk("R3 clear protect", v, 8'h00);
        wr1(7'h0F, 8'hBF); rd1(7'h0F, v); chk("R3 ctrl mask", v, 8'h07);
        wr1(7'h0F, 8'h00); rd1(7'h0F, v); chk("R3 ctrl clear enables", v, 8'h00);

        // R4 / R10: time burst from 0x80, read back in one burst
        t7 = '{8'h59, 8'h37, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99};
        for (int k = 0; k < 7; k++) rbuf[k] = t7[k];
        wr_burst(7'h00, 7);
        rd_burst(7'h00, 7);
        for (int k = 0; k < 7; k++) chk("R4/R10 time burst", rbuf[k], t7[k]);

        // R11: hours encodings
        wr1(7'h02, 8'h72); rd1(7'h02, v); chk("R11 12h PM 12", v, 8'h72);
        wr1(7'h02, 8'h41); rd1(7'h02, v); chk("R11 12h AM 1", v, 8'h41);
        wr1(7'h02, 8'h19); rd1(7'h02, v); chk("R11 24h 19", v, 8'h19);

        // R5 / R6: two complementary sweeps over every address
        for (int p = 0; p < 2; p++) begin
            for (int a = 0; a < 128; a++) begin
                logic [7:0] d;
                d = 8'((a * 37 + 11) & 255);
                if (p == 1) d = ~d;
                if (a == 15) d = d & 8'hBF;
                wr1(7'(a), d);
                model[a] = d & bmask(a);
            end
            rd_burst(7'h00, 128);
            for (int a = 0; a < 128; a++) chk("R5/R6 sweep", rbuf[a], model[a]);
        end

        // R7: pointer wraps from 0x7F to 0x00
        rd_burst(7'h7F, 2);
        chk("R7 wrap last", rbuf[0], 8'h00);
        chk("R7 wrap first", rbuf[1], model[0]);

        // R8: byte cut short by CE fall is discarded
        begin
            logic [7:0] junk;
            ce_on(); bits(8'h81, 8, junk); bits(8'hFF, 4, junk); ce_off();
            rd1(7'h01, v); chk("R8 partial data byte", v, model[1]);
            ce_on(); bits(8'h81, 3, junk); ce_off();
            rd1(7'h01, v); chk("R8 partial address byte", v, model[1]);
        end
        chk_released("R9 idle");

        // R12: protect set mid-burst blocks the rest of the burst
        rbuf[0] = 8'h11; rbuf[1] = 8'h40; rbuf[2] = 8'hAA; rbuf[3] = 8'h55;
        wr_burst(7'h0E, 4);
        rd_burst(7'h0E, 4);
        chk("R12 byte before protect", rbuf[0], 8'h11);
        chk("R12 ctrl set", rbuf[1], 8'h40);
        chk("R12 status", rbuf[2], 8'h00);
        chk("R12 blocked after protect", rbuf[3], model[17]);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule